// File: doc/BRIEF.md
# GPIO Bank with Sticky Qualified Inputs

A 32-pin general-purpose I/O bank controlled through a small single-cycle register port. Each pin has a fixed type. Pins 20 to 23 are output-only. Pins 24, 25, 27 and 28 can be inputs or outputs. Pin 22 drives open-drain. Pin 25 can blink. Pins 26 and 29 to 31 are absent. Software chooses, for each pin, whether it is owned by the bank or by its alternate function, which direction it takes, and what level it drives.

Input pins are sampled on a sample tick. The tick comes from a fast bus-rate strobe while the system runs and from a slow real-time strobe while it sleeps. A pin that is seen high on two consecutive ticks latches a sticky status bit, and the bit stays set until software clears it. Each status bit is routed to one of two system event lines: a control-interrupt line or a management-interrupt line. Each line is the OR of the status bits routed to it.

The pad side of the bank provides an output level and an output enable for every pin. It also provides a per-pin ownership select that an outer multiplexer uses to pick between the bank and the alternate function.

Top module: `gpioBank`

## Requirements
- R1: After reset:
  - ownership reads 0 for all pins, so every pin belongs to its alternate function;
  - direction reads 0x1B000000;
  - level reads 0x00200000, so pin 21 is high and the others are low;
  - status, blink enable and routing read 0;
  - blink divisor reads 4;
  - every pad output enable and both event lines are 0.
- R2: A status bit sets only when its pin is sampled high (active high) on two consecutive sample ticks. The pin must also be a bidirectional pin with ownership 1 and direction 1 (input). Cycles without a tick neither count as samples nor break a run of samples.
- R3: Once set, a status bit stays set while the pin returns low. It is cleared by writing 1 to that bit at the status address. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R4: While `sleepMode` is 0, only `runTick` samples the pins. While `sleepMode` is 1, only `rtcTick` samples the pins.
- R5: Pins 26, 29, 30 and 31 read 0 in every per-pin register and ignore writes. Direction bits 20 to 23 read 0 (output) and cannot be changed. Status bits of pins 20 to 23 are always 0. Only bit 25 of blink enable is writable.
- R6: A pin drives its pad (output enable 1) only when its ownership is 1, it is an output-capable pin, and its direction is 0. A push-pull pin drives its level register bit. Pin 22 is open-drain:
  - for level 0 it drives 0 with the output enable on;
  - for level 1 it turns the output enable off.
- R7: The blink divisor defaults to 4. When blink enable bit 25 is 1 and level bit 25 is 1, pad 25 shows a blink phase instead of a steady high. Writing the divisor restarts the phase at low. After k sample ticks the phase is floor(k/div) mod 2, and a divisor of 0 behaves as 1. With blink enable 0 or level 0, pad 25 shows the level.
- R8: `sciEvent` is the OR of the status bits whose routing bit is 0. `smiEvent` is the OR of the status bits whose routing bit is 1. Both update in the cycle after a status change.
- R9: Register addresses are fixed:

  | Address | Register | Access |
  |---|---|---|
  | 0 | ownership | 1 = bank owns the pin |
  | 1 | direction | 1 = input |
  | 2 | level | read/write |
  | 3 | status | write 1 to clear |
  | 4 | blink enable | read/write |
  | 5 | routing | 1 = management event |
  | 6 | blink divisor | low 8 bits |
  | 7 | unused | reads 0, writes ignored |

  `rdData` follows `addr` in the same cycle. A write with `wrEn` high takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| runTick | input | 1 | Sample strobe used while running |
| rtcTick | input | 1 | Sample strobe used while sleeping |
| sleepMode | input | 1 | 1 selects `rtcTick` as the sample tick |
| pinIn | input | 32 | Pad input levels |
| padOut | output | 32 | Pad output levels |
| padOe | output | 32 | Pad output enables |
| gpioSel | output | 32 | 1 = bank owns the pad, 0 = alternate function |
| sciEvent | output | 1 | Control-interrupt event |
| smiEvent | output | 1 | Management-interrupt event |

## Verification
The assertions assume the following about the inputs:
- `pinIn` is already synchronous to `clk`.
- Each tick is a single-cycle strobe.
- `addr` and `wrEn` are stable across a rising edge.

The assertions relating status rises to sample ticks rely on this. The bench drives every input on the falling edge, pulses each tick for exactly one cycle, and changes pin levels only between ticks. Two consecutive samples therefore always mean two separate tick pulses.

// File: rtl/gpioPkg.sv
package gpioPkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_USE   = 3'd0,
    REG_DIR   = 3'd1,
    REG_LVL   = 3'd2,
    REG_STS   = 3'd3,
    REG_BLINK = 3'd4,
    REG_ROUTE = 3'd5,
    REG_DIV   = 3'd6,
    REG_NONE  = 3'd7
  } regAddrT;

  typedef struct packed {
    logic wrUse;
    logic wrDir;
    logic wrLvl;
    logic wrClr;
    logic wrBlink;
    logic wrRoute;
    logic wrDiv;
    logic sampleTick;
    logic blinkToggle;
  } strobesT;

endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              runTick,
  input  logic              rtcTick,
  input  logic              sleepMode,
  input  logic [DIV_W-1:0]  blinkDiv,
  output strobesT           strb
);

  localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

  regAddrT          regSel;
  logic [DIV_W-1:0] tickCnt;
  logic             tickNow;
  logic             wrapNow;

  assign regSel  = regAddrT'(addr);
  assign tickNow = sleepMode ? rtcTick : runTick;
  assign wrapNow = ({1'b0, tickCnt} + ONE) >= {1'b0, blinkDiv};

  always_comb begin
    strb             = '0;
    strb.sampleTick  = tickNow;
    if (wrEn) begin
      unique case (regSel)
        REG_USE:   strb.wrUse   = 1'b1;
        REG_DIR:   strb.wrDir   = 1'b1;
        REG_LVL:   strb.wrLvl   = 1'b1;
        REG_STS:   strb.wrClr   = 1'b1;
        REG_BLINK: strb.wrBlink = 1'b1;
        REG_ROUTE: strb.wrRoute = 1'b1;
        REG_DIV:   strb.wrDiv   = 1'b1;
        default:   ;
      endcase
    end
    strb.blinkToggle = tickNow & wrapNow & ~strb.wrDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.wrDiv) begin
      tickCnt <= '0;
    end else if (tickNow) begin
      tickCnt <= wrapNow ? '0 : tickCnt + 1'b1;
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrUse, strb.wrDir, strb.wrLvl, strb.wrClr,
              strb.wrBlink, strb.wrRoute, strb.wrDiv})); // R9

  AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ((sleepMode && !rtcTick) || (!sleepMode && !runTick)) |-> !strb.sampleTick); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (blinkDiv != '0 && $stable(blinkDiv)) |-> (tickCnt < blinkDiv)); // R7

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int             W          = 32,
  parameter int             DIV_W      = 8,
  parameter logic [W-1:0]   IN_MASK    = 32'h1B00_0000,
  parameter logic [W-1:0]   OUT_MASK   = 32'h1BF0_0000,
  parameter logic [W-1:0]   OD_MASK    = 32'h0040_0000,
  parameter logic [W-1:0]   BLINK_MASK = 32'h0200_0000,
  parameter logic [W-1:0]   LVL_RST    = 32'h0020_0000,
  parameter logic [DIV_W-1:0] DIV_RST  = 8'd4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  input  logic [W-1:0]      pinIn,
  output logic [W-1:0]      rdData,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      gpioSel,
  output logic              sciEvent,
  output logic              smiEvent,
  output logic [DIV_W-1:0]  blinkDiv
);

  localparam logic [W-1:0] IMPL_MASK = IN_MASK | OUT_MASK;

  logic [W-1:0]     useReg, dirReg, lvlReg, stsReg, blinkReg, routeReg;
  logic [W-1:0]     prevSmp, clrVec, setVec, eligible, driveEn;
  logic [DIV_W-1:0] divReg;
  logic             phase;

  assign eligible = IN_MASK & useReg & dirReg;
  assign clrVec   = strb.wrClr ? (wrData & IN_MASK) : '0;
  assign setVec   = strb.sampleTick ? (pinIn & prevSmp & eligible) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useReg   <= '0;
      dirReg   <= IN_MASK;
      lvlReg   <= LVL_RST & OUT_MASK;
      stsReg   <= '0;
      blinkReg <= '0;
      routeReg <= '0;
      prevSmp  <= '0;
      divReg   <= DIV_RST;
      phase    <= 1'b0;
    end else begin
      if (strb.wrUse)   useReg   <= wrData & IMPL_MASK;
      if (strb.wrDir)   dirReg   <= wrData & IN_MASK;
      if (strb.wrLvl)   lvlReg   <= wrData & OUT_MASK;
      if (strb.wrBlink) blinkReg <= wrData & BLINK_MASK;
      if (strb.wrRoute) routeReg <= wrData & IN_MASK;
      if (strb.wrDiv)   divReg   <= wrData[DIV_W-1:0];
      if (strb.sampleTick) prevSmp <= pinIn & IN_MASK;
      stsReg <= (stsReg & ~clrVec) | setVec;
      if (strb.wrDiv)            phase <= 1'b0;
      else if (strb.blinkToggle) phase <= ~phase;
    end
  end

  assign driveEn = useReg & OUT_MASK & ~dirReg;

  for (genvar i = 0; i < W; i++) begin : g_pad
    if (!OUT_MASK[i]) begin : g_absent
      assign padOut[i] = 1'b0;
      assign padOe[i]  = 1'b0;
    end else if (OD_MASK[i]) begin : g_drain
      assign padOut[i] = 1'b0;
      assign padOe[i]  = driveEn[i] & ~lvlReg[i];
    end else if (BLINK_MASK[i]) begin : g_blink
      assign padOut[i] = (blinkReg[i] & lvlReg[i]) ? phase : lvlReg[i];
      assign padOe[i]  = driveEn[i];
    end else begin : g_push
      assign padOut[i] = lvlReg[i];
      assign padOe[i]  = driveEn[i];
    end
  end

  assign gpioSel  = useReg;
  assign blinkDiv = divReg;
  assign sciEvent = |(stsReg & ~routeReg);
  assign smiEvent = |(stsReg & routeReg);

  always_comb begin
    unique case (regAddrT'(addr))
      REG_USE:   rdData = useReg;
      REG_DIR:   rdData = dirReg;
      REG_LVL:   rdData = lvlReg;
      REG_STS:   rdData = stsReg;
      REG_BLINK: rdData = blinkReg;
      REG_ROUTE: rdData = routeReg;
      REG_DIV:   rdData = {{(W-DIV_W){1'b0}}, divReg};
      default:   rdData = '0;
    endcase
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(stsReg) & ~$past(clrVec) & ~stsReg) == '0)); // R3

  AST_STS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((stsReg & ~$past(stsReg)) != '0) |-> $past(strb.sampleTick)); // R2

  AST_STS_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rstN)
    ((stsReg & ~$past(stsReg) & ~$past(prevSmp)) == '0)); // R2

  AST_RD_UNIMPL: assert property (@(posedge clk) disable iff (!rstN)
    (regAddrT'(addr) != REG_DIV) |-> ((rdData & ~IMPL_MASK) == '0)); // R5

  AST_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padOut & OD_MASK) == '0)); // R6

  AST_EVENT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (sciEvent || smiEvent) |-> (stsReg != '0)); // R8

endmodule

// File: rtl/gpioBank.sv
module gpioBank
  import gpioPkg::*;
#(
  parameter int               W          = 32,
  parameter int               DIV_W      = 8,
  parameter logic [W-1:0]     IN_MASK    = 32'h1B00_0000,
  parameter logic [W-1:0]     OUT_MASK   = 32'h1BF0_0000,
  parameter logic [W-1:0]     OD_MASK    = 32'h0040_0000,
  parameter logic [W-1:0]     BLINK_MASK = 32'h0200_0000,
  parameter logic [W-1:0]     LVL_RST    = 32'h0020_0000,
  parameter logic [DIV_W-1:0] DIV_RST    = 8'd4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   addr,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic         runTick,
  input  logic         rtcTick,
  input  logic         sleepMode,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] gpioSel,
  output logic         sciEvent,
  output logic         smiEvent
);

  strobesT          strb;
  logic [DIV_W-1:0] blinkDiv;

  gpioCtrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .runTick   (runTick),
    .rtcTick   (rtcTick),
    .sleepMode (sleepMode),
    .blinkDiv  (blinkDiv),
    .strb      (strb)
  );

  gpioDatapath #(
    .W(W), .DIV_W(DIV_W), .IN_MASK(IN_MASK), .OUT_MASK(OUT_MASK),
    .OD_MASK(OD_MASK), .BLINK_MASK(BLINK_MASK), .LVL_RST(LVL_RST),
    .DIV_RST(DIV_RST)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .padOut   (padOut),
    .padOe    (padOe),
    .gpioSel  (gpioSel),
    .sciEvent (sciEvent),
    .smiEvent (smiEvent),
    .blinkDiv (blinkDiv)
  );

endmodule

// File: tb/test_gpioBank.sv
`timescale 1ns/1ps
module test_gpioBank;

  localparam logic [31:0] IN_M   = 32'h1B00_0000;
  localparam logic [31:0] OUT_M  = 32'h1BF0_0000;
  localparam logic [31:0] OD_M   = 32'h0040_0000;
  localparam logic [31:0] BLK_M  = 32'h0200_0000;
  localparam logic [31:0] IMPL_M = IN_M | OUT_M;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        runTick = 1'b0;
  logic        rtcTick = 1'b0;
  logic        sleepMode = 1'b0;
  logic [31:0] pinIn = '0;
  logic [31:0] padOut, padOe, gpioSel;
  logic        sciEvent, smiEvent;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gpioBank i_gpioBank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .runTick(runTick), .rtcTick(rtcTick),
    .sleepMode(sleepMode), .pinIn(pinIn), .padOut(padOut), .padOe(padOe),
    .gpioSel(gpioSel), .sciEvent(sciEvent), .smiEvent(smiEvent)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic tick(input bit useRtc);
    @(negedge clk);
    if (useRtc) rtcTick = 1'b1; else runTick = 1'b1;
    @(negedge clk);
    rtcTick = 1'b0; runTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, bit1, exp;
    logic [31:0] maskTab [7];
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 use", v, 32'h0);
    rd(3'd1, v); check("R1 dir", v, IN_M);
    rd(3'd2, v); check("R1 lvl", v, 32'h0020_0000);
    rd(3'd3, v); check("R1 sts", v, 32'h0);
    rd(3'd4, v); check("R1 blink", v, 32'h0);
    rd(3'd5, v); check("R1 route", v, 32'h0);
    rd(3'd6, v); check("R1 div", v, 32'd4);
    check("R1 padOe", padOe, 32'h0);
    check("R1 events", {30'h0, sciEvent, smiEvent}, 32'h0);

    // R5 R9 writable masks per address
    maskTab[0] = IMPL_M; maskTab[1] = IN_M; maskTab[2] = OUT_M;
    maskTab[3] = 32'h0;  maskTab[4] = BLK_M; maskTab[5] = IN_M;
    maskTab[6] = 32'h0000_00FF;
    for (int a = 0; a < 7; a++) begin
      wr(3'(a), 32'hFFFF_FFFF); rd(3'(a), v); check("R5 R9 ones", v, maskTab[a]);
      wr(3'(a), 32'h0);         rd(3'(a), v); check("R5 R9 zeros", v, 32'h0);
    end
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, v); check("R9 unused addr", v, 32'h0);

    // R2 R3 R8 per-pin sweep of sticky status
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd6, 32'd4);
    for (int i = 0; i < 32; i++) begin
      bit1 = 32'h1 << i;
      exp  = bit1 & IN_M;
      pinIn = bit1;
      tick(0); rd(3'd3, v); check("R2 one tick", v, 32'h0);
      tick(0); rd(3'd3, v); check("R2 two ticks", v, exp);
      check("R8 sci", {31'h0, sciEvent}, {31'h0, exp != 0});
      pinIn = '0;
      tick(0); rd(3'd3, v); check("R3 sticky", v, exp);
      wr(3'd3, 32'h0); rd(3'd3, v); check("R3 write0", v, exp);
      wr(3'd3, bit1);  rd(3'd3, v); check("R3 clear", v, 32'h0);
      tick(0);
    end

    // R2 broken run of samples
    pinIn = 32'h0100_0000; tick(0);
    pinIn = 32'h0; tick(0);
    pinIn = 32'h0100_0000; tick(0);
    rd(3'd3, v); check("R2 not consecutive", v, 32'h0);
    // R2 cycles without tick do not break the run
    repeat (5) @(negedge clk);
    tick(0); rd(3'd3, v); check("R2 gap between ticks", v, 32'h0100_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    // R2 not owned
    wr(3'd0, 32'h0); tick(0); tick(0);
    rd(3'd3, v); check("R2 alt owned", v, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    // R2 direction output
    wr(3'd1, 32'h0); tick(0); tick(0);
    rd(3'd3, v); check("R2 dir output", v, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    pinIn = 32'h0; tick(0);

    // R3 set wins over simultaneous clear
    pinIn = 32'h0200_0000; tick(0); tick(0);
    @(negedge clk);
    runTick = 1'b1; addr = 3'd3; wrData = 32'h0200_0000; wrEn = 1'b1;
    @(negedge clk);
    runTick = 1'b0; wrEn = 1'b0;
    rd(3'd3, v); check("R3 set beats clear", v, 32'h0200_0000);
    pinIn = 32'h0; wr(3'd3, 32'h0200_0000);
    rd(3'd3, v); check("R3 clear after", v, 32'h0);

    // R4 tick source selection
    tick(0);
    sleepMode = 1'b1; pinIn = 32'h0800_0000;
    tick(0); tick(0);
    rd(3'd3, v); check("R4 run tick ignored asleep", v, 32'h0);
    tick(1); tick(1);
    rd(3'd3, v); check("R4 rtc tick asleep", v, 32'h0800_0000);
    sleepMode = 1'b0; pinIn = 32'h0;
    wr(3'd3, 32'hFFFF_FFFF);
    pinIn = 32'h0800_0000; tick(1); tick(1);
    rd(3'd3, v); check("R4 rtc tick ignored awake", v, 32'h0);
    pinIn = 32'h0; tick(0);

    // R8 routing
    wr(3'd5, 32'h1000_0000);
    pinIn = 32'h1000_0000; tick(0); tick(0);
    #1 check("R8 smi only", {30'h0, sciEvent, smiEvent}, 32'h1);
    pinIn = 32'h1100_0000; tick(0); tick(0);
    #1 check("R8 both", {30'h0, sciEvent, smiEvent}, 32'h3);
    pinIn = 32'h0; wr(3'd3, 32'hFFFF_FFFF);
    #1 check("R8 cleared", {30'h0, sciEvent, smiEvent}, 32'h0);
    wr(3'd5, 32'h0);

    // R6 pad drive per bit
    wr(3'd1, 32'h0);
    for (int i = 0; i < 32; i++) begin
      bit1 = (32'h1 << i) & OUT_M;
      wr(3'd2, 32'h1 << i);
      #1;
      check("R6 padOut", padOut, bit1 & ~OD_M);
      check("R6 padOe", padOe, OUT_M & ~(OD_M & bit1));
    end
    wr(3'd0, 32'h0); #1 check("R6 alt owned", padOe, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'h0);
    #1 check("R6 inputs off", padOe, 32'h00F0_0000);
    wr(3'd1, 32'h0);

    // R7 blink sweep over divisors
    wr(3'd2, 32'h0200_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    for (int d = 0; d <= 5; d++) begin
      wr(3'd6, 32'(d));
      for (int k = 0; k <= 12; k++) begin
        #1 check("R7 blink phase", {31'h0, padOut[25]},
                 {31'h0, 1'((k / ((d == 0) ? 1 : d)) % 2)});
        tick(0);
      end
    end
    wr(3'd4, 32'h0); #1 check("R7 blink off", {31'h0, padOut[25]}, 32'h1);
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd2, 32'h0);
    tick(0); tick(0); tick(0); tick(0); tick(0);
    #1 check("R7 level low", {31'h0, padOut[25]}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule